// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block turns a UART's FIFO fill levels and error pulses into interrupt state. From the receive and transmit occupancy counts and two programmable trigger levels, it forms a live status word each cycle. Every cycle it also folds the live conditions, together with single-cycle pulses for receive overrun, framing error, parity error, receiver timeout, modem status change and transmit overrun, into a sticky flag register. Software clears that register by writing ones to it.

An interrupt mask decides which sticky flags reach the single level-sensitive interrupt output. Software can set mask bits only through an enable address and clear them only through a disable address. The mask address itself is read-only. All registers sit behind a small valid/ready register bus. A read returns its data exactly one cycle after the request is accepted.

Top module: `uart_irq_status_ctrl`

## Requirements
- R1: Live status word, bit 0 = RX count >= RX trigger level, bit 1 = RX count is 0, bit 2 = RX count equals the FIFO depth (64), bit 3 = TX count is 0, bit 4 = TX count equals the FIFO depth; the word follows the counts combinationally.
- R2: The TX trigger condition (TX count >= TX trigger level) appears at bit 13 of the live status word and is latched at bit 10 of the sticky flag register, never at bit 13.
- R3: On every clock edge, live status bits 0 to 4 are ORed into the same sticky bit positions, and a latched bit stays set after its condition goes away.
- R4: Event pulses latch into sticky bits: RX overrun bit 5, framing error bit 6, parity error bit 7, receiver timeout bit 8, modem status change bit 9, TX overrun bit 12.
- R5: A write to address 0 ORs the data into the mask, a write to address 1 clears the mask bits written as 1, and a write to address 2 (the mask) leaves the mask unchanged.
- R6: A write to address 3 (sticky flags) clears exactly the bits written as 1 and leaves the other bits as they were.
- R7: When a clearing write and a set condition hit the same sticky bit in one cycle, the bit ends up set.
- R8: The interrupt output is high exactly when some bit is set in both the mask and the sticky register.
- R9: After reset the mask and sticky registers are 0 and both trigger levels (address 5 for RX, address 6 for TX) read 32.
- R10: Requests are accepted whenever reset is released. A read of address 2, 3, 4 (live status), 5 or 6 returns the current value with response valid exactly one cycle later. Addresses 0 and 1 read as 0, and a write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_rx_timeout | input | 1 | Receiver timeout pulse |
| ev_modem_chg | input | 1 | Modem status change pulse |
| ev_tx_overrun | input | 1 | Transmit overrun pulse |
| req_valid | input | 1 | Register request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| stat_word | output | 14 | Live status word |
| irq_flags | output | 13 | Sticky flag register |
| irq_out | output | 1 | Level interrupt |

## Verification
The bench places the FIFO counts on both sides of each boundary: 31 and 32 around the trigger level, 0, and the full depth. A design with an off-by-one compare would raise or drop bit 0 or bit 13 at the wrong count. It also checks that the TX trigger latches at sticky bit 10. A design that copied the live word straight across would show it at bit 13 instead. It drives a clearing write in the same cycle as a parity pulse. A design that let the clear win would silently lose that event. Writes to the mask address are checked for no effect, and a partial clear is checked for wiping out other pending flags.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  localparam int ADDR_W = 4;
  localparam int STAT_W = 14;
  localparam int IRQ_W  = 13;
  localparam int LIVE_N = 5;
  localparam int EVT_N  = 6;

  localparam int B_RX_TRIG      = 0;
  localparam int B_RX_EMPTY     = 1;
  localparam int B_RX_FULL      = 2;
  localparam int B_TX_EMPTY     = 3;
  localparam int B_TX_FULL      = 4;
  localparam int B_RX_OVR       = 5;
  localparam int B_FRAME        = 6;
  localparam int B_PARITY       = 7;
  localparam int B_TIMEOUT      = 8;
  localparam int B_MODEM        = 9;
  localparam int B_TX_TRIG_FLAG = 10;
  localparam int B_TX_OVR       = 12;
  localparam int B_TX_TRIG_STAT = 13;

  // event vector index -> sticky bit position
  localparam int EVT_POS [EVT_N] = '{B_RX_OVR, B_FRAME, B_PARITY, B_TIMEOUT, B_MODEM, B_TX_OVR};

  typedef enum logic [ADDR_W-1:0] {
    A_ENABLE  = 4'd0,
    A_DISABLE = 4'd1,
    A_MASK    = 4'd2,
    A_STICKY  = 4'd3,
    A_LIVE    = 4'd4,
    A_RX_LVL  = 4'd5,
    A_TX_LVL  = 4'd6
  } reg_addr_e;
endpackage

// File: rtl/ucs_rst_sync.sv
module ucs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/ucs_status_gen.sv
module ucs_status_gen
  import ucs_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int FIFO_DEPTH = 64
) (
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_lvl,
  input  logic [CNT_W-1:0]  tx_lvl,
  input  logic [EVT_N-1:0]  ev_vec,
  output logic [STAT_W-1:0] stat_word,
  output logic [IRQ_W-1:0]  set_vec
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  always_comb begin
    stat_word                 = '0;
    stat_word[B_RX_TRIG]      = (rx_count >= rx_lvl);
    stat_word[B_RX_EMPTY]     = (rx_count == '0);
    stat_word[B_RX_FULL]      = (rx_count == FULL_CNT);
    stat_word[B_TX_EMPTY]     = (tx_count == '0);
    stat_word[B_TX_FULL]      = (tx_count == FULL_CNT);
    stat_word[B_TX_TRIG_STAT] = (tx_count >= tx_lvl);
  end

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < LIVE_N; i++) begin
      set_vec[i] = stat_word[i];
    end
    set_vec[B_TX_TRIG_FLAG] = stat_word[B_TX_TRIG_STAT];
    for (int e = 0; e < EVT_N; e++) begin
      set_vec[EVT_POS[e]] = ev_vec[e];
    end
  end
endmodule

// File: rtl/ucs_sticky.sv
module ucs_sticky
  import ucs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_vec,
  input  logic [IRQ_W-1:0] clr_vec,
  output logic [IRQ_W-1:0] sticky_q
);
  logic [IRQ_W-1:0] sticky_d;
  logic             sticky_en;

  always_comb begin
    sticky_en = (|set_vec) | (|clr_vec);
    sticky_d  = (sticky_q & ~clr_vec) | set_vec;  // set has priority
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
    end else if (sticky_en) begin
      sticky_q <= sticky_d;
    end
  end
endmodule

// File: rtl/ucs_reg_if.sv
module ucs_reg_if
  import ucs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 7,
  parameter int LVL_RST = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [STAT_W-1:0] stat_word,
  input  logic [IRQ_W-1:0]  sticky_q,
  output logic [IRQ_W-1:0]  mask_q,
  output logic [IRQ_W-1:0]  clr_vec,
  output logic [CNT_W-1:0]  rx_lvl_q,
  output logic [CNT_W-1:0]  tx_lvl_q
);
  logic              acc_rd, acc_wr;
  logic [IRQ_W-1:0]  mask_d;
  logic              mask_en;
  logic [CNT_W-1:0]  lvl_d;
  logic              rx_lvl_en, tx_lvl_en;
  logic [DATA_W-1:0] rdata_d;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  assign req_ready = rst_n;
  assign acc_rd    = req_valid & req_ready & ~req_write;
  assign acc_wr    = req_valid & req_ready & req_write;
  assign lvl_d     = req_wdata[CNT_W-1:0];

  // write decode
  always_comb begin
    mask_d    = mask_q;
    mask_en   = 1'b0;
    rx_lvl_en = 1'b0;
    tx_lvl_en = 1'b0;
    clr_vec   = '0;
    if (acc_wr) begin
      case (req_addr)
        A_ENABLE: begin
          mask_d  = mask_q | req_wdata[IRQ_W-1:0];
          mask_en = 1'b1;
        end
        A_DISABLE: begin
          mask_d  = mask_q & ~req_wdata[IRQ_W-1:0];
          mask_en = 1'b1;
        end
        A_STICKY: clr_vec   = req_wdata[IRQ_W-1:0];
        A_RX_LVL: rx_lvl_en = 1'b1;
        A_TX_LVL: tx_lvl_en = 1'b1;
        default:  ;
      endcase
    end
  end

  // read mux
  always_comb begin
    rdata_d = '0;
    case (req_addr)
      A_MASK:   rdata_d = DATA_W'(mask_q);
      A_STICKY: rdata_d = DATA_W'(sticky_q);
      A_LIVE:   rdata_d = DATA_W'(stat_word);
      A_RX_LVL: rdata_d = DATA_W'(rx_lvl_q);
      A_TX_LVL: rdata_d = DATA_W'(tx_lvl_q);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q      <= '0;
      rx_lvl_q    <= CNT_W'(LVL_RST);
      tx_lvl_q    <= CNT_W'(LVL_RST);
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      if (mask_en)   mask_q   <= mask_d;
      if (rx_lvl_en) rx_lvl_q <= lvl_d;
      if (tx_lvl_en) tx_lvl_q <= lvl_d;
      rsp_valid_q <= acc_rd;
      if (acc_rd)    rsp_rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/uart_irq_status_ctrl.sv
module uart_irq_status_ctrl
  import ucs_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int FIFO_DEPTH = 64,
  parameter int DATA_W     = 32,
  parameter int LVL_RST    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              ev_rx_overrun,
  input  logic              ev_frame_err,
  input  logic              ev_parity_err,
  input  logic              ev_rx_timeout,
  input  logic              ev_modem_chg,
  input  logic              ev_tx_overrun,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [STAT_W-1:0] stat_word,
  output logic [IRQ_W-1:0]  irq_flags,
  output logic              irq_out
);
  logic             rst_sync_n;
  logic [EVT_N-1:0] ev_vec;
  logic [IRQ_W-1:0] set_vec, clr_vec, mask_q, sticky_q;
  logic [CNT_W-1:0] rx_lvl_q, tx_lvl_q;

  assign ev_vec = {ev_tx_overrun, ev_modem_chg, ev_rx_timeout,
                   ev_parity_err, ev_frame_err, ev_rx_overrun};

  ucs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ucs_status_gen #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) u_stat (
    .rx_count  (rx_count),
    .tx_count  (tx_count),
    .rx_lvl    (rx_lvl_q),
    .tx_lvl    (tx_lvl_q),
    .ev_vec    (ev_vec),
    .stat_word (stat_word),
    .set_vec   (set_vec)
  );

  ucs_reg_if #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LVL_RST(LVL_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .stat_word (stat_word),
    .sticky_q  (sticky_q),
    .mask_q    (mask_q),
    .clr_vec   (clr_vec),
    .rx_lvl_q  (rx_lvl_q),
    .tx_lvl_q  (tx_lvl_q)
  );

  ucs_sticky u_sticky (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .sticky_q (sticky_q)
  );

  assign irq_flags = sticky_q;
  assign irq_out   = |(mask_q & sticky_q);
endmodule

// File: rtl/ucs_checker.sv
module ucs_checker
  import ucs_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [CNT_W-1:0]  rx_count,
  input logic              ev_rx_overrun,
  input logic              ev_parity_err,
  input logic              ev_tx_overrun,
  input logic [STAT_W-1:0] stat_word,
  input logic [IRQ_W-1:0]  sticky_q,
  input logic [IRQ_W-1:0]  mask_q,
  input logic              irq_out
);
  logic rd_acc, mask_wr, par_clr;
  assign rd_acc  = req_valid && !req_write;
  assign mask_wr = req_valid && req_write &&
                   (req_addr == A_ENABLE || req_addr == A_DISABLE);
  assign par_clr = req_valid && req_write && req_addr == A_STICKY && req_wdata[B_PARITY];

  AST_EMPTY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |=> sticky_q[B_RX_EMPTY]);  // R3
  AST_TXTRIG_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[B_TX_TRIG_STAT] |=> sticky_q[B_TX_TRIG_FLAG]);  // R2
  AST_RXOVR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_overrun |=> sticky_q[B_RX_OVR]);  // R4
  AST_TXOVR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_overrun |=> sticky_q[B_TX_OVR]);  // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (par_clr && ev_parity_err) |=> sticky_q[B_PARITY]);  // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (par_clr && !ev_parity_err) |=> !sticky_q[B_PARITY]);  // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));  // R5
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mask_q != '0));  // R8
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);  // R10
  AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rsp_valid);  // R10
endmodule

bind uart_irq_status_ctrl ucs_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_addr      (req_addr),
  .req_wdata     (req_wdata),
  .rsp_valid     (rsp_valid),
  .rx_count      (rx_count),
  .ev_rx_overrun (ev_rx_overrun),
  .ev_parity_err (ev_parity_err),
  .ev_tx_overrun (ev_tx_overrun),
  .stat_word     (stat_word),
  .sticky_q      (sticky_q),
  .mask_q        (mask_q),
  .irq_out       (irq_out)
);

// File: tb/test_uart_irq_status_ctrl.sv
module test_uart_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  rx_count, tx_count;
  logic [5:0]  evs;
  logic        req_valid, req_write;
  logic [3:0]  req_addr;
  logic [31:0] req_wdata;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [13:0] stat_word;
  logic [12:0] irq_flags;
  logic        irq_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] val; string req; } exp_t;
  exp_t exp_q[$];

  localparam int EV_BIT [6] = '{5, 6, 7, 8, 9, 12};

  always #2 clk = ~clk;

  uart_irq_status_ctrl i_uart_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .ev_rx_overrun(evs[0]), .ev_frame_err(evs[1]), .ev_parity_err(evs[2]),
    .ev_rx_timeout(evs[3]), .ev_modem_chg(evs[4]), .ev_tx_overrun(evs[5]),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .stat_word(stat_word), .irq_flags(irq_flags),
    .irq_out(irq_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: compare read responses against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, rsp_rdata, e.val);
      end
    end
  end

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back('{exp, req});
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 response one cycle later", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse(int idx);
    @(negedge clk);
    evs[idx] = 1'b1;
    @(negedge clk);
    evs[idx] = 1'b0;
  endtask

  // drive counts, check the live word, restore, check what was latched
  task automatic pattern(logic [6:0] rx, logic [6:0] tx, logic [13:0] exp_stat,
                         logic [12:0] exp_flags, string req);
    @(negedge clk);
    rx_count = rx; tx_count = tx;
    #1 check({req, " live"}, {18'd0, stat_word}, {18'd0, exp_stat});
    @(negedge clk);
    rx_count = 7'd1; tx_count = 7'd1;
    rd(4'd3, {19'd0, exp_flags}, {req, " sticky"});
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, 32'd0, "R6 clear all");
  endtask

  initial begin
    #400000;
    n_errors++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_count = 7'd1; tx_count = 7'd1; evs = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    check("R9 irq after reset", {31'd0, irq_out}, 32'd0);
    check("R1 live idle", {18'd0, stat_word}, 32'd0);
    check("R10 ready", {31'd0, req_ready}, 32'd1);
    rd(4'd2, 32'd0, "R9 mask");
    rd(4'd3, 32'd0, "R9 sticky");
    rd(4'd5, 32'd32, "R9 rx level");
    rd(4'd6, 32'd32, "R9 tx level");
    rd(4'd0, 32'd0, "R10 enable reads zero");

    // R1 / R2 / R3 count patterns
    pattern(7'd0,  7'd1,  14'h0002, 13'h0002, "R1 R3 rx empty");
    pattern(7'd64, 7'd1,  14'h0005, 13'h0005, "R1 rx full");
    pattern(7'd1,  7'd0,  14'h0008, 13'h0008, "R1 tx empty");
    pattern(7'd1,  7'd64, 14'h2010, 13'h0410, "R2 tx full");
    pattern(7'd1,  7'd40, 14'h2000, 13'h0400, "R2 tx trigger");
    pattern(7'd31, 7'd31, 14'h0000, 13'h0000, "R1 below trigger");
    pattern(7'd32, 7'd32, 14'h2001, 13'h0401, "R1 R2 at trigger");

    // programmable levels
    wr(4'd5, 32'd4);
    wr(4'd6, 32'd2);
    rd(4'd5, 32'd4, "R1 rx level write");
    rd(4'd6, 32'd2, "R2 tx level write");
    pattern(7'd3, 7'd1, 14'h0000, 13'h0000, "R1 rx below level 4");
    pattern(7'd4, 7'd2, 14'h2001, 13'h0401, "R1 R2 new levels");
    wr(4'd5, 32'd32);
    wr(4'd6, 32'd32);
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd4, 32'd0, "R10 live read");

    // R4 events
    for (int i = 0; i < 6; i++) begin
      pulse(i);
      rd(4'd3, 32'd1 << EV_BIT[i], "R4 event bit");
      wr(4'd3, 32'd1 << EV_BIT[i]);
      rd(4'd3, 32'd0, "R6 event cleared");
    end

    // R6 partial clear
    pulse(0);
    pulse(1);
    wr(4'd3, 32'h20);
    rd(4'd3, 32'h40, "R6 partial clear");
    wr(4'd3, 32'hFFFF_FFFF);

    // R5 mask
    wr(4'd0, 32'hA0);
    rd(4'd2, 32'hA0, "R5 enable");
    wr(4'd1, 32'h20);
    rd(4'd2, 32'h80, "R5 disable");
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, 32'h80, "R5 direct mask write ignored");
    wr(4'd0, 32'h01);
    rd(4'd2, 32'h81, "R5 enable keeps set bits");
    wr(4'd1, 32'h01);

    // R8 interrupt
    check("R8 idle", {31'd0, irq_out}, 32'd0);
    pulse(1);
    check("R8 unmasked flag", {31'd0, irq_out}, 32'd0);
    pulse(2);
    check("R8 masked flag", {31'd0, irq_out}, 32'd1);
    wr(4'd3, 32'h80);
    check("R8 after clear", {31'd0, irq_out}, 32'd0);
    wr(4'd3, 32'hFFFF_FFFF);

    // R7 set wins over clear
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd3; req_wdata = 32'h80;
    evs[2] = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; evs[2] = 1'b0;
    check("R7 irq stays", {31'd0, irq_out}, 32'd1);
    rd(4'd3, 32'h80, "R7 set wins");
    wr(4'd1, 32'hFFFF_FFFF);
    check("R8 mask cleared", {31'd0, irq_out}, 32'd0);
    rd(4'd2, 32'd0, "R5 disable all");

    repeat (3) @(negedge clk);
    check("R10 responses drained", exp_q.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    done = 1'b1;
    $finish;
  end
endmodule